// File: doc/BRIEF.md
# Active priority tracker

This block holds the two per-group active-priority bitmaps of a virtual interrupt CPU interface. When an interrupt is acknowledged, its 8-bit priority is reduced to a preemption level by masking off the sub-priority bits that the group's binary point selects. The level is then scaled down by the minimum binary point and marks one bit in that group's bitmap. The block reports the running priority, which is the highest active level across both groups. On end-of-interrupt it performs a priority drop, which removes the highest active level and returns it.

The block also holds the two binary point settings and the flag that makes Group-1 share Group-0's binary point. It enforces the lower limits on binary point writes. Software can read and replace any bitmap word directly. The number of preemption bits is a parameter (5, 6 or 7), and it gives 1, 2 or 4 words of 32 bits per group. Every result is registered.

Top module: `apr_tracker`

## Requirements
- R1: After reset both bitmaps are zero, `run_prio` is 0xFF, `drop_valid` is 0, `drop_level` is 0xFF, `cbp_q` is 0, `bpr0_q` is the minimum binary point minus 1 and `bpr1_q` is the minimum binary point. The minimum binary point is 8 minus PREEMPT_BITS.
- R2: An acknowledge sets one bit in the bitmap of `ack_group` (0 = Group-0, 1 = Group-1). For Group-0 the effective binary point is `bpr0_q`+1. The level is `ack_prio` AND (0xFF shifted left by the effective binary point), shifted right by the minimum binary point. The level divided by 32 selects the word and the remainder selects the bit.
- R3: For Group-1 the effective binary point is the stored Group-1 value while the common flag is clear. While the flag is set it is `bpr0_q`+1, saturated at 7.
- R4: `run_prio` is the index of the lowest set bit in the OR of both bitmaps (words in ascending order, 32 bits each), shifted left by the minimum binary point. It is 0xFF when both bitmaps are empty. It reflects every change in the same edge that makes the change.
- R5: A drop request clears the lowest set bit across both groups. If both groups hold that bit, the Group-1 bit is cleared. One edge later `drop_valid` pulses and `drop_level` carries the cleared index scaled like `run_prio`, or 0xFF if nothing was active. In that case the bitmaps are left unchanged.
- R6: A Group-0 binary point write (`bp_wr_sel`=0) stores the data clamped to at least the minimum binary point minus 1.
- R7: A Group-1 binary point write (`bp_wr_sel`=1) stores the data clamped to at least the minimum binary point. The write is ignored while the common flag is set.
- R8: While the common flag is set, `bpr1_q` shows the derived value `bpr0_q`+1 saturated at 7. Otherwise it shows the stored Group-1 value.
- R9: When a drop and an acknowledge arrive in the same cycle, the drop acts on the bitmaps as they were before that edge, and the new bit is set afterwards.
- R10: A software write replaces word `sw_word` of the group chosen by `sw_group`. A software read returns word `sw_rd_word` of group `sw_rd_group` on `sw_rdata` one edge later. A word index beyond the configured count reads as zero.
- R11: A software write to a word overrides any set or clear that the same cycle applies to that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_valid | input | 1 | Acknowledge pulse: mark the priority active |
| ack_group | input | 1 | Group of the acknowledge (0 or 1) |
| ack_prio | input | 8 | Priority of the acknowledged interrupt |
| drop_req | input | 1 | Priority drop pulse |
| bp_wr_en | input | 1 | Binary point write strobe |
| bp_wr_sel | input | 1 | 0 writes the Group-0 value, 1 writes the Group-1 value |
| bp_wr_data | input | 3 | Binary point write data |
| cbp_wr_en | input | 1 | Common-flag write strobe |
| cbp_wr_data | input | 1 | Common-flag write data |
| sw_wr_en | input | 1 | Software bitmap word write strobe |
| sw_group | input | 1 | Group of the software write |
| sw_word | input | WIDX_W | Word index of the software write |
| sw_wdata | input | 32 | Software write data |
| sw_rd_group | input | 1 | Group of the software read |
| sw_rd_word | input | WIDX_W | Word index of the software read |
| sw_rdata | output | 32 | Software read data, one edge after the address |
| run_prio | output | 8 | Running priority |
| drop_valid | output | 1 | Pulses one edge after a drop request |
| drop_level | output | 8 | Level removed by the last drop, 0xFF if none |
| bpr0_q | output | 3 | Group-0 binary point |
| bpr1_q | output | 3 | Group-1 binary point as seen by software |
| cbp_q | output | 1 | Common binary point flag |

## Verification
Every result of this block is due at the first rising edge after its request. This holds for the running priority after an acknowledge, drop or software write, for the drop level and its valid pulse, for the binary point views, and for software read data. The bench therefore drives each request on a falling edge and removes it on the next falling edge, where it also samples the outputs. This sample point lies half a period after the edge that updated them. Same-cycle cases (a drop with an acknowledge, a software write with an acknowledge) are driven together on one falling edge so that the ordering rules can be observed at the same sample point.

// File: rtl/apr_pkg.sv
package apr_pkg;
  localparam int PRIO_W = 8;
  localparam int WORD_W = 32;
  localparam int BP_W   = 3;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [BP_W-1:0]   bp_t;

  localparam prio_t IDLE_PRIO = 8'hFF;
  localparam bp_t   BP_SAT    = 3'd7;
endpackage

// File: rtl/apr_lsb_find.sv
// Returns the index of the lowest set bit of a vector.
module apr_lsb_find #(
  parameter int N  = 128,
  parameter int IW = 7
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/apr_bp_ctrl.sv
// Binary point registers, write limiting and priority-to-level conversion.
module apr_bp_ctrl
  import apr_pkg::*;
#(
  parameter int BPR_MIN = 1,
  parameter int IDX_W   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bp_wr_en,
  input  logic             bp_wr_sel,
  input  bp_t              bp_wr_data,
  input  logic             cbp_wr_en,
  input  logic             cbp_wr_data,
  input  logic             ack_group,
  input  prio_t            ack_prio,
  output logic [IDX_W-1:0] ack_idx,
  output bp_t              bpr0_q,
  output bp_t              bpr1_q,
  output logic             cbp_q
);
  localparam bp_t FLOOR0 = bp_t'(BPR_MIN - 1);
  localparam bp_t FLOOR1 = bp_t'(BPR_MIN);

  bp_t  bpr0_r, bpr1_r, bpr0_n, bpr1_n;
  logic cbp_r, cbp_n;

  function automatic bp_t derive1(bp_t b0);
    return (b0 == BP_SAT) ? BP_SAT : b0 + 3'd1;
  endfunction

  always_comb begin
    bpr0_n = bpr0_r;
    bpr1_n = bpr1_r;
    cbp_n  = cbp_wr_en ? cbp_wr_data : cbp_r;
    if (bp_wr_en && !bp_wr_sel)
      bpr0_n = (int'(bp_wr_data) < BPR_MIN - 1) ? FLOOR0 : bp_wr_data;
    if (bp_wr_en && bp_wr_sel && !cbp_r)
      bpr1_n = (int'(bp_wr_data) < BPR_MIN) ? FLOOR1 : bp_wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bpr0_r <= FLOOR0;
      bpr1_r <= FLOOR1;
      cbp_r  <= 1'b0;
      bpr1_q <= FLOOR1;
    end else begin
      bpr0_r <= bpr0_n;
      bpr1_r <= bpr1_n;
      cbp_r  <= cbp_n;
      bpr1_q <= cbp_n ? derive1(bpr0_n) : bpr1_n;
    end
  end

  assign bpr0_q = bpr0_r;
  assign cbp_q  = cbp_r;

  logic [3:0] eff_bp;
  prio_t      pre_lvl;

  always_comb begin
    if (!ack_group) eff_bp = {1'b0, bpr0_r} + 4'd1;
    else if (cbp_r) eff_bp = {1'b0, derive1(bpr0_r)};
    else            eff_bp = {1'b0, bpr1_r};
    pre_lvl = ack_prio & (8'hFF << eff_bp);
    ack_idx = IDX_W'(pre_lvl >> BPR_MIN);
  end
endmodule

// File: rtl/apr_bitmap_store.sv
// Two-group active bitmaps with clear, set and software word access.
module apr_bitmap_store
  import apr_pkg::*;
#(
  parameter int NWORDS = 4,
  parameter int IDX_W  = 7,
  parameter int WIDX_W = 2,
  parameter int TOT    = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              set_en,
  input  logic              set_grp,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic              sw_wr_en,
  input  logic              sw_grp,
  input  logic [WIDX_W-1:0] sw_word,
  input  logic [WORD_W-1:0] sw_wdata,
  input  logic              sw_rd_grp,
  input  logic [WIDX_W-1:0] sw_rd_word,
  output logic [WORD_W-1:0] sw_rdata,
  output logic [TOT-1:0]    g0_q,
  output logic [TOT-1:0]    g1_q,
  output logic [TOT-1:0]    g0_n,
  output logic [TOT-1:0]    g1_n
);
  logic [TOT-1:0] clr0, clr1, set0, set1;

  always_comb begin
    clr0 = '0;
    clr1 = '0;
    set0 = '0;
    set1 = '0;
    if (clr_en) begin
      if (g1_q[clr_idx]) clr1[clr_idx] = 1'b1;
      else               clr0[clr_idx] = 1'b1;
    end
    if (set_en) begin
      if (set_grp) set1[set_idx] = 1'b1;
      else         set0[set_idx] = 1'b1;
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic hit0, hit1;
    assign hit0 = sw_wr_en && !sw_grp && (sw_word == WIDX_W'(w));
    assign hit1 = sw_wr_en &&  sw_grp && (sw_word == WIDX_W'(w));
    assign g0_n[w*WORD_W +: WORD_W] = hit0 ? sw_wdata :
      ((g0_q[w*WORD_W +: WORD_W] & ~clr0[w*WORD_W +: WORD_W]) | set0[w*WORD_W +: WORD_W]);
    assign g1_n[w*WORD_W +: WORD_W] = hit1 ? sw_wdata :
      ((g1_q[w*WORD_W +: WORD_W] & ~clr1[w*WORD_W +: WORD_W]) | set1[w*WORD_W +: WORD_W]);
  end

  logic [TOT-1:0] rd_vec;
  assign rd_vec = sw_rd_grp ? g1_q : g0_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      g0_q     <= '0;
      g1_q     <= '0;
      sw_rdata <= '0;
    end else begin
      g0_q <= g0_n;
      g1_q <= g1_n;
      if (int'(sw_rd_word) < NWORDS)
        sw_rdata <= rd_vec[int'(sw_rd_word)*WORD_W +: WORD_W];
      else
        sw_rdata <= '0;
    end
  end
endmodule

// File: rtl/apr_tracker.sv
module apr_tracker
  import apr_pkg::*;
#(
  parameter int  PREEMPT_BITS = 7,
  localparam int BPR_MIN      = 8 - PREEMPT_BITS,
  localparam int NWORDS       = 1 << (PREEMPT_BITS - 5),
  localparam int TOT          = NWORDS * WORD_W,
  localparam int IDX_W        = PREEMPT_BITS,
  localparam int WIDX_W       = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_valid,
  input  logic              ack_group,
  input  logic [7:0]        ack_prio,
  input  logic              drop_req,
  input  logic              bp_wr_en,
  input  logic              bp_wr_sel,
  input  logic [2:0]        bp_wr_data,
  input  logic              cbp_wr_en,
  input  logic              cbp_wr_data,
  input  logic              sw_wr_en,
  input  logic              sw_group,
  input  logic [WIDX_W-1:0] sw_word,
  input  logic [31:0]       sw_wdata,
  input  logic              sw_rd_group,
  input  logic [WIDX_W-1:0] sw_rd_word,
  output logic [31:0]       sw_rdata,
  output logic [7:0]        run_prio,
  output logic              drop_valid,
  output logic [7:0]        drop_level,
  output logic [2:0]        bpr0_q,
  output logic [2:0]        bpr1_q,
  output logic              cbp_q
);
  logic [IDX_W-1:0] ack_idx, drop_idx, run_idx;
  logic             drop_found, run_found;
  logic [TOT-1:0]   g0_q, g1_q, g0_n, g1_n;

  apr_bp_ctrl #(.BPR_MIN(BPR_MIN), .IDX_W(IDX_W)) u_bp (
    .clk(clk), .rst(rst),
    .bp_wr_en(bp_wr_en), .bp_wr_sel(bp_wr_sel), .bp_wr_data(bp_wr_data),
    .cbp_wr_en(cbp_wr_en), .cbp_wr_data(cbp_wr_data),
    .ack_group(ack_group), .ack_prio(ack_prio), .ack_idx(ack_idx),
    .bpr0_q(bpr0_q), .bpr1_q(bpr1_q), .cbp_q(cbp_q)
  );

  // Highest active level before this edge: the one a drop removes.
  apr_lsb_find #(.N(TOT), .IW(IDX_W)) u_drop_find (
    .vec(g0_q | g1_q), .found(drop_found), .idx(drop_idx)
  );

  apr_bitmap_store #(.NWORDS(NWORDS), .IDX_W(IDX_W), .WIDX_W(WIDX_W), .TOT(TOT)) u_store (
    .clk(clk), .rst(rst),
    .clr_en(drop_req && drop_found), .clr_idx(drop_idx),
    .set_en(ack_valid), .set_grp(ack_group), .set_idx(ack_idx),
    .sw_wr_en(sw_wr_en), .sw_grp(sw_group), .sw_word(sw_word), .sw_wdata(sw_wdata),
    .sw_rd_grp(sw_rd_group), .sw_rd_word(sw_rd_word), .sw_rdata(sw_rdata),
    .g0_q(g0_q), .g1_q(g1_q), .g0_n(g0_n), .g1_n(g1_n)
  );

  // Highest active level after this edge: registered as the running priority.
  apr_lsb_find #(.N(TOT), .IW(IDX_W)) u_run_find (
    .vec(g0_n | g1_n), .found(run_found), .idx(run_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_prio   <= IDLE_PRIO;
      drop_valid <= 1'b0;
      drop_level <= IDLE_PRIO;
    end else begin
      run_prio   <= run_found ? (prio_t'(run_idx) << BPR_MIN) : IDLE_PRIO;
      drop_valid <= drop_req;
      if (drop_req)
        drop_level <= drop_found ? (prio_t'(drop_idx) << BPR_MIN) : IDLE_PRIO;
    end
  end
endmodule

// File: rtl/apr_tracker_chk.sv
module apr_tracker_chk #(
  parameter int BPR_MIN = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       ack_valid,
  input logic       drop_req,
  input logic       bp_wr_en,
  input logic       bp_wr_sel,
  input logic [2:0] bp_wr_data,
  input logic       sw_wr_en,
  input logic [7:0] run_prio,
  input logic       drop_valid,
  input logic [7:0] drop_level,
  input logic [2:0] bpr0_q,
  input logic [2:0] bpr1_q,
  input logic       cbp_q
);
  p_drop_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    drop_req |=> drop_valid);

  p_drop_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !drop_req |=> !drop_valid);

  // The drop search and the running-priority search are separate encoders.
  p_drop_matches_run_r4: assert property (@(posedge clk) disable iff (rst)
    drop_req |=> drop_level == $past(run_prio));

  p_ack_visible_r2: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !sw_wr_en) |=> run_prio != 8'hFF);

  p_bpr0_store_r6: assert property (@(posedge clk) disable iff (rst)
    (bp_wr_en && !bp_wr_sel && int'(bp_wr_data) >= BPR_MIN - 1) |=> bpr0_q == $past(bp_wr_data));

  p_bpr1_derived_r8: assert property (@(posedge clk) disable iff (rst)
    cbp_q |-> bpr1_q == ((bpr0_q == 3'd7) ? 3'd7 : bpr0_q + 3'd1));

  p_bpr1_floor_r7: assert property (@(posedge clk) disable iff (rst)
    !cbp_q |-> int'(bpr1_q) >= BPR_MIN);
endmodule

bind apr_tracker apr_tracker_chk #(.BPR_MIN(BPR_MIN)) u_chk (
  .clk(clk), .rst(rst), .ack_valid(ack_valid), .drop_req(drop_req),
  .bp_wr_en(bp_wr_en), .bp_wr_sel(bp_wr_sel), .bp_wr_data(bp_wr_data),
  .sw_wr_en(sw_wr_en), .run_prio(run_prio), .drop_valid(drop_valid),
  .drop_level(drop_level), .bpr0_q(bpr0_q), .bpr1_q(bpr1_q), .cbp_q(cbp_q)
);

// File: tb/apr_tracker_tb.sv
`timescale 1ns/1ps
module apr_tracker_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        ack_valid = 0, ack_group = 0, drop_req = 0;
  logic [7:0]  ack_prio = 0;
  logic        bp_wr_en = 0, bp_wr_sel = 0, cbp_wr_en = 0, cbp_wr_data = 0;
  logic [2:0]  bp_wr_data = 0;
  logic        sw_wr_en = 0, sw_group = 0, sw_rd_group = 0;
  logic [1:0]  sw_word = 0, sw_rd_word = 0;
  logic [31:0] sw_wdata = 0, sw_rdata;
  logic [7:0]  run_prio, drop_level;
  logic        drop_valid, cbp_q;
  logic [2:0]  bpr0_q, bpr1_q;

  apr_tracker u_dut (
    .clk(clk), .rst(rst), .ack_valid(ack_valid), .ack_group(ack_group), .ack_prio(ack_prio),
    .drop_req(drop_req), .bp_wr_en(bp_wr_en), .bp_wr_sel(bp_wr_sel), .bp_wr_data(bp_wr_data),
    .cbp_wr_en(cbp_wr_en), .cbp_wr_data(cbp_wr_data), .sw_wr_en(sw_wr_en), .sw_group(sw_group),
    .sw_word(sw_word), .sw_wdata(sw_wdata), .sw_rd_group(sw_rd_group), .sw_rd_word(sw_rd_word),
    .sw_rdata(sw_rdata), .run_prio(run_prio), .drop_valid(drop_valid), .drop_level(drop_level),
    .bpr0_q(bpr0_q), .bpr1_q(bpr1_q), .cbp_q(cbp_q)
  );

  // Narrow instance: 5 preemption bits, minimum binary point 3, one word.
  logic        b_ack = 0, b_bp_en = 0, b_bp_sel = 0;
  logic [7:0]  b_prio = 0;
  logic [2:0]  b_bp_data = 0;
  logic [0:0]  b_rd_word = 0;
  logic [31:0] b_rdata;
  logic [7:0]  b_run, b_lvl;
  logic        b_dv, b_cbp;
  logic [2:0]  b_bpr0, b_bpr1;

  apr_tracker #(.PREEMPT_BITS(5)) u_dut5 (
    .clk(clk), .rst(rst), .ack_valid(b_ack), .ack_group(1'b0), .ack_prio(b_prio),
    .drop_req(1'b0), .bp_wr_en(b_bp_en), .bp_wr_sel(b_bp_sel), .bp_wr_data(b_bp_data),
    .cbp_wr_en(1'b0), .cbp_wr_data(1'b0), .sw_wr_en(1'b0), .sw_group(1'b0),
    .sw_word(1'b0), .sw_wdata(32'h0), .sw_rd_group(1'b0), .sw_rd_word(b_rd_word),
    .sw_rdata(b_rdata), .run_prio(b_run), .drop_valid(b_dv), .drop_level(b_lvl),
    .bpr0_q(b_bpr0), .bpr1_q(b_bpr1), .cbp_q(b_cbp)
  );

  int n_checks = 0;
  int n_errors = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic release_all();
    ack_valid = 0; drop_req = 0; bp_wr_en = 0; cbp_wr_en = 0; sw_wr_en = 0;
    b_ack = 0; b_bp_en = 0;
  endtask

  task automatic do_ack(logic g, logic [7:0] p);
    @(negedge clk); ack_valid = 1; ack_group = g; ack_prio = p;
    @(negedge clk); release_all();
  endtask

  task automatic do_drop();
    @(negedge clk); drop_req = 1;
    @(negedge clk); release_all();
  endtask

  task automatic do_bp(logic sel, logic [2:0] d);
    @(negedge clk); bp_wr_en = 1; bp_wr_sel = sel; bp_wr_data = d;
    @(negedge clk); release_all();
  endtask

  task automatic do_cbp(logic v);
    @(negedge clk); cbp_wr_en = 1; cbp_wr_data = v;
    @(negedge clk); release_all();
  endtask

  task automatic do_swwr(logic g, logic [1:0] w, logic [31:0] d);
    @(negedge clk); sw_wr_en = 1; sw_group = g; sw_word = w; sw_wdata = d;
    @(negedge clk); release_all();
  endtask

  task automatic do_swrd(logic g, logic [1:0] w, output logic [31:0] d);
    @(negedge clk); sw_rd_group = g; sw_rd_word = w;
    @(negedge clk); d = sw_rdata;
  endtask

  // {drop, group, prio, expected drop level, expected running priority}
  localparam logic [25:0] VEC [12] = '{
    {1'b0, 1'b0, 8'h80, 8'h00, 8'h80},
    {1'b0, 1'b1, 8'h41, 8'h00, 8'h40},
    {1'b0, 1'b0, 8'h05, 8'h00, 8'h04},
    {1'b0, 1'b1, 8'h05, 8'h00, 8'h04},
    {1'b1, 1'b0, 8'h00, 8'h04, 8'h04},
    {1'b1, 1'b0, 8'h00, 8'h04, 8'h40},
    {1'b1, 1'b0, 8'h00, 8'h40, 8'h80},
    {1'b1, 1'b0, 8'h00, 8'h80, 8'hFF},
    {1'b1, 1'b0, 8'h00, 8'hFF, 8'hFF},
    {1'b0, 1'b1, 8'hFF, 8'h00, 8'hFE},
    {1'b1, 1'b0, 8'h00, 8'hFE, 8'hFF},
    {1'b1, 1'b0, 8'h00, 8'hFF, 8'hFF}
  };

  bit done = 0;

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    check("R1 run_prio", run_prio, 8'hFF);
    check("R1 drop_valid", drop_valid, 0);
    check("R1 drop_level", drop_level, 8'hFF);
    check("R1 bpr0", bpr0_q, 0);
    check("R1 bpr1", bpr1_q, 1);
    check("R1 cbp", cbp_q, 0);
    check("R1 narrow bpr0", b_bpr0, 2);
    check("R1 narrow bpr1", b_bpr1, 3);
    do_swrd(1'b0, 2'd0, rd);
    check("R1 bitmap word", rd, 0);

    // R2 R4 R5 table: acknowledges and drops with default binary points
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][25]) begin
        do_drop();
        check("R5 drop_valid", drop_valid, 1);
        check("R5 drop_level", drop_level, VEC[i][15:8]);
      end else begin
        do_ack(VEC[i][24], VEC[i][23:16]);
      end
      check("R4 run_prio", run_prio, VEC[i][7:0]);
    end
    @(negedge clk);
    check("R5 drop_valid low", drop_valid, 0);

    // R3 Group-1 level with and without the common flag
    do_bp(1'b0, 3'd3);
    do_ack(1'b1, 8'h37);
    check("R3 own bp", run_prio, 8'h36);
    do_drop();
    check("R3 drop own", drop_level, 8'h36);
    do_cbp(1'b1);
    check("R8 derived view", bpr1_q, 3'd4);
    do_ack(1'b1, 8'h37);
    check("R3 common bp", run_prio, 8'h30);
    do_drop();
    do_bp(1'b0, 3'd7);
    check("R8 saturated view", bpr1_q, 3'd7);
    do_ack(1'b1, 8'h37);
    check("R3 saturated bp", run_prio, 8'h00);
    do_drop();
    check("R3 drop level 0", drop_level, 8'h00);
    check("R4 empty after drop", run_prio, 8'hFF);

    // R7 Group-1 write ignored while common, clamped otherwise
    do_bp(1'b1, 3'd5);
    do_cbp(1'b0);
    check("R7 ignored write", bpr1_q, 3'd1);
    do_bp(1'b1, 3'd0);
    check("R7 clamp", bpr1_q, 3'd1);
    do_bp(1'b1, 3'd4);
    check("R7 store", bpr1_q, 3'd4);
    do_bp(1'b1, 3'd1);
    do_bp(1'b0, 3'd0);
    check("R6 store zero", bpr0_q, 3'd0);

    // R6 clamp on the narrow instance (minimum binary point 3)
    @(negedge clk); b_bp_en = 1; b_bp_sel = 0; b_bp_data = 3'd0;
    @(negedge clk); release_all();
    check("R6 narrow clamp", b_bpr0, 3'd2);
    @(negedge clk); b_bp_en = 1; b_bp_sel = 1; b_bp_data = 3'd1;
    @(negedge clk); release_all();
    check("R7 narrow clamp", b_bpr1, 3'd3);
    @(negedge clk); b_ack = 1; b_prio = 8'h55;
    @(negedge clk); release_all();
    check("R2 narrow level", b_run, 8'h50);
    @(negedge clk); b_rd_word = 1'b0;
    @(negedge clk);
    check("R10 narrow word", b_rdata, 32'h0000_0400);
    @(negedge clk); b_rd_word = 1'b1;
    @(negedge clk);
    check("R10 out of range", b_rdata, 0);

    // R9 same-cycle drop and acknowledge
    do_ack(1'b0, 8'h80);
    @(negedge clk); drop_req = 1; ack_valid = 1; ack_group = 1; ack_prio = 8'h10;
    @(negedge clk); release_all();
    check("R9 drop level", drop_level, 8'h80);
    check("R9 run after", run_prio, 8'h10);
    do_drop();
    check("R9 second drop", drop_level, 8'h10);

    // R10 software write and read
    do_swwr(1'b1, 2'd1, 32'h0000_0100);
    check("R10 run from sw", run_prio, 8'h50);
    do_swrd(1'b1, 2'd1, rd);
    check("R10 read g1", rd, 32'h0000_0100);
    do_swrd(1'b0, 2'd1, rd);
    check("R10 read g0", rd, 0);
    do_swwr(1'b1, 2'd1, 32'h0);
    check("R10 cleared", run_prio, 8'hFF);

    // R11 software write overrides same-cycle set
    @(negedge clk); sw_wr_en = 1; sw_group = 0; sw_word = 0; sw_wdata = 32'h8;
    ack_valid = 1; ack_group = 0; ack_prio = 8'h02;
    @(negedge clk); release_all();
    check("R11 run", run_prio, 8'h06);
    do_swrd(1'b0, 2'd0, rd);
    check("R11 word", rd, 32'h8);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule